// File: doc/BRIEF.md
# Threshold-Filtered Performance Event Counter

This block is one performance-monitoring counter with its own configuration register. Every clock cycle an upstream event source presents a small count of the events that happened in that cycle. The counter either adds that count as it is, or, with its threshold filter switched on, adds one for each cycle whose count passes a programmable 4-bit threshold test. A complement bit inverts the sense of the test. Threshold 15 with the complement set passes in every cycle, which turns the counter into a clock-cycle counter with no dedicated clock-event source.

Counting is qualified in four ways. The configuration enable bit must be set. The event selector must report that a real event is selected. The event beat must be valid. The thread or package must be awake, and a mode pin picks which test applies. In per-thread mode, a cycle counts only while the thread named in the configuration is running. In package-wide mode, cycles count unless every thread is halted and the package is also powered down. Software reads and writes the configuration and the counter value through a one-bit-address register port. The counter wraps at 2^40 and raises a sticky overflow flag.

The event input uses a valid/ready handshake with no buffering. `evt_ready` is high in every cycle except one in which the register port loads the counter. A beat offered in such a cycle is not accepted and is dropped. The source samples events per cycle and never holds a beat waiting for ready.

Top module: `perf_event_counter`

## Requirements
- R1: With the enable bit (configuration bit 0) clear, the counter value does not change.
- R2: With the compare bit (configuration bit 1) clear, each qualified cycle adds `evt_count` (0..15) to the counter.
- R3: With the compare bit set and the complement bit (configuration bit 2) clear, a qualified cycle adds one when `evt_count` is strictly greater than the threshold (configuration bits 6:3), and zero otherwise.
- R4: With the compare and complement bits set, a qualified cycle adds one when `evt_count` is less than or equal to the threshold. Threshold 15 therefore adds one in every qualified cycle, whatever the count.
- R5: While `evt_sel_valid` is low, the counter does not increment.
- R6: With `gate_mode` = 0 (per-thread), a cycle counts only if `thread_halted[tid]` is low, where tid is configuration bit 7.
- R7: With `gate_mode` = 1 (package-wide), a cycle counts unless all `thread_halted` bits are high and `pkg_sleep` is high.
- R8: The 40-bit counter wraps to zero past 2^40-1 and sets `ovf_flag`. The flag stays set through later increments, and a write to the counter clears it.
- R9: A register write to address 1 loads the counter, takes priority over any increment in that cycle, and is read back on the next cycle. `evt_ready` is low in that cycle.
- R10: After reset the configuration, the counter and `ovf_flag` are zero. `reg_rdata` shows the configuration at address 0 (bits 7:0, upper bits zero) and the counter at address 1, both combinationally.
- R11: A cycle with `evt_valid` low adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event beat valid for this cycle |
| evt_ready | output | 1 | Beat accepted; low only during a counter load |
| evt_count | input | EVT_W (4) | Events that occurred this cycle |
| evt_sel_valid | input | 1 | A real event source is selected |
| thread_halted | input | NTHR (2) | Per-thread halted flags |
| pkg_sleep | input | 1 | Package is in its power-saving state |
| gate_mode | input | 1 | 0 per-thread gating, 1 package-wide gating |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 configuration, 1 counter |
| reg_wdata | input | CNT_W (40) | Write data |
| reg_rdata | output | CNT_W (40) | Read data for `reg_addr` |
| ovf_flag | output | 1 | Sticky counter overflow |

## Verification
The bench targets the edges of the threshold test: counts equal to the threshold, one above it, and zero. A design with an off-by-one comparison would miscount these by one per cycle. It drives threshold 15 with the complement set and a count of 15, where a comparison with the wrong sense would stop counting. It drives both gating modes with the owning thread halted, with only the other thread halted, and with all threads halted with and without package sleep. A design that confused the modes or used the wrong thread index would count where it must hold. It loads the counter near 2^40 in the same cycle as an event, then lets it wrap, so a design that let the increment win, lost the wrap or cleared the flag early shows a wrong value or flag.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int NTHR  = 2;
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam int THR_W = 4;
  localparam int CFG_W = 3 + THR_W + TID_W;

  // Configuration layout, LSB first: en, cmp, cpl, thr, tid
  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic [THR_W-1:0] thr;
    logic             cpl;
    logic             cmp;
    logic             en;
  } cfg_t;

  typedef enum logic {
    GATE_PER_THREAD = 1'b0,
    GATE_PACKAGE    = 1'b1
  } gate_mode_e;

  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CNT = 1'b1;
endpackage

// File: rtl/perf_cfg_reg.sv
module perf_cfg_reg
  import perf_cnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_t'(wdata);
  end
endmodule

// File: rtl/perf_gate.sv
module perf_gate
  import perf_cnt_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             evt_valid,
  input  logic [EVT_W-1:0] evt_count,
  input  logic             evt_sel_valid,
  input  logic [NTHR-1:0]  thread_halted,
  input  logic             pkg_sleep,
  input  gate_mode_e       mode,
  output logic [EVT_W-1:0] inc
);
  localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

  logic [CMP_W-1:0] cnt_x, thr_x;
  logic             awake, pass, qualified;

  assign cnt_x = CMP_W'(evt_count);
  assign thr_x = CMP_W'(cfg.thr);

  // Sleep/halt gating selected by the mode pin
  always_comb begin
    unique case (mode)
      GATE_PER_THREAD: awake = !thread_halted[cfg.tid];
      GATE_PACKAGE:    awake = !((&thread_halted) && pkg_sleep);
      default:         awake = 1'b0;
    endcase
  end

  // Threshold test with complement sense
  assign pass      = cfg.cpl ? (cnt_x <= thr_x) : (cnt_x > thr_x);
  assign qualified = cfg.en && evt_sel_valid && evt_valid && awake;

  always_comb begin
    if (!qualified)   inc = '0;
    else if (cfg.cmp) inc = EVT_W'(pass);
    else              inc = evt_count;
  end

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> inc == '0);  // R1
  AST_CMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.cmp |-> inc <= EVT_W'(1));  // R3
  AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_sel_valid |-> inc == '0);  // R5
  AST_ALL_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_PACKAGE && (&thread_halted) && pkg_sleep) |-> inc == '0);  // R7
  AST_OWN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_PER_THREAD && thread_halted[cfg.tid]) |-> inc == '0);  // R6
  AST_NOVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> inc == '0);  // R11
endmodule

// File: rtl/perf_accum.sv
module perf_accum #(
  parameter int CNT_W = 40,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, count} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (ld) begin
      count <= ld_val;
      ovf   <= 1'b0;
    end else begin
      count <= sum[CNT_W-1:0];
      if (sum[CNT_W]) ovf <= 1'b1;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(ld_val));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc == '0) |=> $stable(count));  // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ld) |=> ovf);  // R8
  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !ovf);  // R8
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [EVT_W-1:0] evt_count,
  input  logic             evt_sel_valid,
  input  logic [NTHR-1:0]  thread_halted,
  input  logic             pkg_sleep,
  input  logic             gate_mode,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             ovf_flag
);
  cfg_t             cfg_q;
  logic [EVT_W-1:0] inc;
  logic [CNT_W-1:0] count;
  logic             cfg_wr, cnt_ld;

  assign cfg_wr    = reg_wr && (reg_addr == ADDR_CFG);
  assign cnt_ld    = reg_wr && (reg_addr == ADDR_CNT);
  assign evt_ready = !cnt_ld;

  perf_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (reg_wdata[CFG_W-1:0]),
    .cfg_q (cfg_q)
  );

  perf_gate #(.EVT_W(EVT_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg           (cfg_q),
    .evt_valid     (evt_valid),
    .evt_count     (evt_count),
    .evt_sel_valid (evt_sel_valid),
    .thread_halted (thread_halted),
    .pkg_sleep     (pkg_sleep),
    .mode          (gate_mode_e'(gate_mode)),
    .inc           (inc)
  );

  perf_accum #(.CNT_W(CNT_W), .INC_W(EVT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cnt_ld),
    .ld_val (reg_wdata),
    .inc    (inc),
    .count  (count),
    .ovf    (ovf_flag)
  );

  assign reg_rdata = (reg_addr == ADDR_CNT) ? count : CNT_W'(cfg_q);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ovf_flag);  // R10
endmodule

// File: tb/perf_event_counter_test.sv
`timescale 1ns/1ps
module perf_event_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_sel_valid = 1'b0, pkg_sleep = 1'b0, gate_mode = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [3:0]  evt_count = '0;
  logic [1:0]  thread_halted = '0;
  logic [39:0] reg_wdata = '0;
  logic [39:0] reg_rdata;
  logic        evt_ready, ovf_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [39:0] exp_q[$];
  logic        exp_ovf_q[$];
  string       tag_q[$];

  logic [39:0] m_cnt = '0;
  logic [7:0]  m_cfg = '0;
  logic        m_ovf = 1'b0;

  always #4 clk = ~clk;

  perf_event_counter uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_count(evt_count), .evt_sel_valid(evt_sel_valid), .thread_halted(thread_halted),
    .pkg_sleep(pkg_sleep), .gate_mode(gate_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic v, input logic [3:0] n, input logic sel,
                      input logic [1:0] h, input logic sl, input logic md,
                      input logic wr, input logic a, input logic [39:0] wd,
                      input string tag);
    logic run, pass;
    logic [3:0] inc;
    logic [40:0] sum;
    @(negedge clk);
    evt_valid = v; evt_count = n; evt_sel_valid = sel; thread_halted = h;
    pkg_sleep = sl; gate_mode = md; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    run  = md ? !((&h) && sl) : !h[m_cfg[7]];
    pass = m_cfg[2] ? (n <= m_cfg[6:3]) : (n > m_cfg[6:3]);
    if (m_cfg[0] && sel && v && run) inc = m_cfg[1] ? {3'b0, pass} : n;
    else inc = 4'd0;
    if (wr && a) begin
      m_cnt = wd; m_ovf = 1'b0;
    end else begin
      sum = {1'b0, m_cnt} + {37'b0, inc};
      m_cnt = sum[39:0];
      if (sum[40]) m_ovf = 1'b1;
    end
    if (wr && !a) m_cfg = wd[7:0];
    exp_q.push_back(a ? m_cnt : {32'b0, m_cfg});
    exp_ovf_q.push_back(m_ovf);
    tag_q.push_back(tag);
    #1 check({tag, " ready (R9)"}, {39'b0, evt_ready}, {39'b0, !(wr && a)});
  endtask

  task automatic wcfg(input logic [7:0] c, input string tag);
    step(1'b0, 4'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, {32'b0, c}, tag);
  endtask

  task automatic ev(input logic [3:0] n, input string tag);
    step(1'b1, n, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 40'd0, tag);
  endtask

  // Monitor: compares each result just after the edge that produces it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [39:0] e;
        logic eo;
        string t;
        e = exp_q.pop_front(); eo = exp_ovf_q.pop_front(); t = tag_q.pop_front();
        check({t, " rdata"}, reg_rdata, e);
        check({t, " ovf"}, {39'b0, ovf_flag}, {39'b0, eo});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    reg_addr = 1'b0; #1 check("R10 cfg", reg_rdata, 40'd0);
    reg_addr = 1'b1; #1 check("R10 cnt", reg_rdata, 40'd0);
    check("R10 ovf", {39'b0, ovf_flag}, 40'd0);

    // R1 disabled
    wcfg(8'h00, "R10 cfg readback");
    ev(4'd5, "R1"); ev(4'd9, "R1");
    // R2 raw counts
    wcfg(8'h01, "R10 cfg readback");
    ev(4'd3, "R2"); ev(4'd7, "R2"); ev(4'd15, "R2"); ev(4'd0, "R2");
    // R11 valid low
    step(1'b0, 4'd9, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 40'd0, "R11");
    // R5 no event selected
    step(1'b1, 4'd6, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 40'd0, "R5");
    // R3 greater-than threshold 5
    wcfg(8'h01 | 8'h02 | (8'd5 << 3), "R3 cfg");
    ev(4'd5, "R3"); ev(4'd6, "R3"); ev(4'd15, "R3"); ev(4'd0, "R3");
    // R4 complement threshold 5, then 15
    wcfg(8'h07 | (8'd5 << 3), "R4 cfg");
    ev(4'd5, "R4"); ev(4'd6, "R4"); ev(4'd0, "R4");
    wcfg(8'h07 | (8'd15 << 3), "R4 cfg");
    ev(4'd15, "R4"); ev(4'd9, "R4"); ev(4'd0, "R4");
    // R6 per-thread gating, own thread 1
    wcfg(8'h81, "R6 cfg");
    step(1'b1, 4'd4, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 40'd0, "R6");
    step(1'b1, 4'd4, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 40'd0, "R6");
    // R7 package-wide gating
    step(1'b1, 4'd2, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 40'd0, "R7");
    step(1'b1, 4'd2, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 40'd0, "R7");
    step(1'b1, 4'd2, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 40'd0, "R7");
    // R9 load beats increment, R8 wrap and sticky flag
    step(1'b1, 4'd4, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 40'hFF_FFFF_FFFD, "R9");
    ev(4'd4, "R8"); ev(4'd2, "R8");
    step(1'b1, 4'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 40'd100, "R8 clear");
    ev(4'd1, "R8");

    step(1'b0, 4'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 40'd0, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule